// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the combinational arithmetic and logic unit of a load-store RISC integer pipeline. Each cycle it takes two register operands, a 16-bit instruction immediate with a flag that substitutes the immediate for the second operand, a constant shift count, and a 5-bit operation code. It returns a 32-bit result and a single overflow-exception flag.

The unit covers add and subtract in a trapping and a non-trapping flavour, the four bitwise operations, signed and unsigned set-on-less-than, left, logical-right and arithmetic-right shifts by a constant or by a register count, and placing the immediate in the upper half of the word. Arithmetic and compare operations sign-extend the immediate. Bitwise operations zero-extend it. Only the two trapping forms can raise the overflow flag. Suppressing writeback and taking the exception are left to the surrounding pipeline.

Top module: `alu_core`

## Requirements
- R1: Codes 0 (trapping add), 1 (non-trapping add), 2 (trapping subtract) and 3 (non-trapping subtract) return A plus or minus the second operand, modulo 2^32.
- R2: For codes 0 and 2, `overflowTrap` is 1 exactly when the signed result does not fit in 32 bits in two's complement.
- R3: `overflowTrap` is 0 for every code other than 0 and 2. This includes the non-trapping add and subtract forms even when they wrap.
- R4: When `immSel` is 1, codes 0 to 3, 8 and 9 use the immediate sign-extended from bit 15 as the second operand.
- R5: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR, the inverse of A OR B) work bitwise. When `immSel` is 1, they use the immediate zero-extended as the second operand.
- R6: Code 8 returns 1 when A is less than the second operand as two's-complement numbers, otherwise 0. Code 9 makes the same comparison on unsigned numbers.
- R7: Codes 10 (left), 11 (logical right) and 12 (arithmetic right) shift A by `shamt`. Logical shifts fill vacated bits with 0. The arithmetic shift fills them with bit 31 of A.
- R8: Codes 13, 14 and 15 perform the same three shifts by bits 4:0 of B. The upper bits of B and the value of `immSel` have no effect.
- R9: Code 16 returns the immediate in bits 31:16 with bits 15:0 cleared.
- R10: Codes 17 to 31 return a result of 0 with `overflowTrap` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First register operand; also the value that is shifted |
| opB | input | 32 | Second register operand; its low 5 bits give the count for variable shifts |
| imm | input | 16 | Instruction immediate |
| immSel | input | 1 | 1 replaces opB with the extended immediate as the second operand |
| shamt | input | 5 | Constant shift count |
| opCode | input | 5 | Operation code, values as listed in the requirements |
| result | output | 32 | Operation result |
| overflowTrap | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The checker assumes that all inputs hold known values whenever it evaluates. It skips any evaluation in which an input is unknown, because the block has no reset of its own. The bench sets every input before the first check and then changes them only at rising clock edges, so each comparison sees settled, fully defined operands. Random stimulus covers all 32 operation codes, including the undefined ones. Directed vectors add the signed-overflow edges, immediates with bit 15 set, shift counts of 0 and 31, and variable counts whose upper bits are nonzero.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_SLL  = 5'd10,
    OP_SRL  = 5'd11,
    OP_SRA  = 5'd12,
    OP_SLLV = 5'd13,
    OP_SRLV = 5'd14,
    OP_SRAV = 5'd15,
    OP_LUI  = 5'd16
  } aluOp_e;

  typedef enum logic [2:0] {
    RES_ZERO  = 3'd0,
    RES_ADD   = 3'd1,
    RES_LOGIC = 3'd2,
    RES_SLT   = 3'd3,
    RES_SHIFT = 3'd4,
    RES_UPPER = 3'd5
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logicOp_e;

  typedef struct packed {
    resSel_e  resSel;
    logic     subtract;
    logic     trapEn;
    logic     immSignExt;
    logic     useImm;
    logic     shiftLeft;
    logic     shiftArith;
    logic     shiftVar;
    logic     cmpUnsigned;
    logicOp_e logicOp;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic [OP_W-1:0] opCode,
  input  logic            immSel,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.resSel = RES_ZERO;
    ctrl.logicOp = LG_AND;
    case (opCode)
      OP_ADD: begin
        ctrl.resSel = RES_ADD; ctrl.trapEn = 1'b1;
        ctrl.immSignExt = 1'b1; ctrl.useImm = immSel;
      end
      OP_ADDU: begin
        ctrl.resSel = RES_ADD;
        ctrl.immSignExt = 1'b1; ctrl.useImm = immSel;
      end
      OP_SUB: begin
        ctrl.resSel = RES_ADD; ctrl.subtract = 1'b1; ctrl.trapEn = 1'b1;
        ctrl.immSignExt = 1'b1; ctrl.useImm = immSel;
      end
      OP_SUBU: begin
        ctrl.resSel = RES_ADD; ctrl.subtract = 1'b1;
        ctrl.immSignExt = 1'b1; ctrl.useImm = immSel;
      end
      OP_AND: begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_AND; ctrl.useImm = immSel; end
      OP_OR:  begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_OR;  ctrl.useImm = immSel; end
      OP_XOR: begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_XOR; ctrl.useImm = immSel; end
      OP_NOR: begin ctrl.resSel = RES_LOGIC; ctrl.logicOp = LG_NOR; ctrl.useImm = immSel; end
      OP_SLT: begin
        ctrl.resSel = RES_SLT; ctrl.subtract = 1'b1;
        ctrl.immSignExt = 1'b1; ctrl.useImm = immSel;
      end
      OP_SLTU: begin
        ctrl.resSel = RES_SLT; ctrl.subtract = 1'b1; ctrl.cmpUnsigned = 1'b1;
        ctrl.immSignExt = 1'b1; ctrl.useImm = immSel;
      end
      OP_SLL:  begin ctrl.resSel = RES_SHIFT; ctrl.shiftLeft = 1'b1; end
      OP_SRL:  begin ctrl.resSel = RES_SHIFT; end
      OP_SRA:  begin ctrl.resSel = RES_SHIFT; ctrl.shiftArith = 1'b1; end
      OP_SLLV: begin ctrl.resSel = RES_SHIFT; ctrl.shiftLeft = 1'b1; ctrl.shiftVar = 1'b1; end
      OP_SRLV: begin ctrl.resSel = RES_SHIFT; ctrl.shiftVar = 1'b1; end
      OP_SRAV: begin ctrl.resSel = RES_SHIFT; ctrl.shiftArith = 1'b1; ctrl.shiftVar = 1'b1; end
      OP_LUI:  begin ctrl.resSel = RES_UPPER; end
      default: begin ctrl.resSel = RES_ZERO; end
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  aluCtrl_t           ctrl,
  output logic [WIDTH-1:0]   result,
  output logic               overflowTrap
);

  localparam int MSB   = WIDTH - 1;
  localparam int EXT_W = WIDTH - IMM_W;

  // second operand selection with per-class immediate extension
  logic [WIDTH-1:0] immExt;
  logic [WIDTH-1:0] operandB;

  always_comb begin
    if (ctrl.immSignExt) immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
    else                 immExt = {{EXT_W{1'b0}}, imm};
    operandB = ctrl.useImm ? immExt : opB;
  end

  // shared adder: A + B or A + ~B + 1
  logic [WIDTH-1:0] addendB;
  logic [WIDTH:0]   sumFull;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             ovfRaw;
  logic             lessSigned;
  logic             lessUnsigned;

  always_comb begin
    addendB      = ctrl.subtract ? ~operandB : operandB;
    sumFull      = {1'b0, opA} + {1'b0, addendB} + {{WIDTH{1'b0}}, ctrl.subtract};
    sum          = sumFull[WIDTH-1:0];
    carryOut     = sumFull[WIDTH];
    ovfRaw       = (opA[MSB] == addendB[MSB]) && (sum[MSB] != opA[MSB]);
    lessSigned   = sum[MSB] ^ ovfRaw;
    lessUnsigned = ~carryOut;
  end

  // bitwise unit
  logic [WIDTH-1:0] logicRes;
  always_comb begin
    case (ctrl.logicOp)
      LG_AND:  logicRes = opA & operandB;
      LG_OR:   logicRes = opA | operandB;
      LG_XOR:  logicRes = opA ^ operandB;
      default: logicRes = ~(opA | operandB);
    endcase
  end

  // logarithmic shifter: right shifts only, left shift by bit reversal
  logic [SHAMT_W-1:0] shCount;
  logic [WIDTH-1:0]   shIn;
  logic               fillBit;
  logic [WIDTH-1:0]   stage [0:SHAMT_W];
  logic [WIDTH-1:0]   shOut;

  always_comb begin
    shCount = ctrl.shiftVar ? opB[SHAMT_W-1:0] : shamt;
    fillBit = ctrl.shiftArith & opA[MSB];
    for (int k = 0; k < WIDTH; k++) begin
      shIn[k] = ctrl.shiftLeft ? opA[MSB-k] : opA[k];
    end
  end

  assign stage[0] = shIn;

  genvar g;
  generate
    for (g = 0; g < SHAMT_W; g++) begin : gShiftStage
      localparam int STEP = 1 << g;
      if (STEP < WIDTH) begin : gPartial
        assign stage[g+1] = shCount[g]
          ? {{STEP{fillBit}}, stage[g][WIDTH-1:STEP]}
          : stage[g];
      end else begin : gFull
        assign stage[g+1] = shCount[g] ? {WIDTH{fillBit}} : stage[g];
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      shOut[k] = ctrl.shiftLeft ? stage[SHAMT_W][MSB-k] : stage[SHAMT_W][k];
    end
  end

  // result selection
  always_comb begin
    case (ctrl.resSel)
      RES_ADD:   result = sum;
      RES_LOGIC: result = logicRes;
      RES_SLT:   result = {{(WIDTH-1){1'b0}},
                           (ctrl.cmpUnsigned ? lessUnsigned : lessSigned)};
      RES_SHIFT: result = shOut;
      RES_UPPER: result = {imm, {EXT_W{1'b0}}};
      default:   result = '0;
    endcase
    overflowTrap = ctrl.trapEn & ovfRaw & (ctrl.resSel == RES_ADD);
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int IMM_W   = 16,
  parameter int OP_W    = 5,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [IMM_W-1:0]   imm,
  input  logic               immSel,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [OP_W-1:0]    opCode,
  output logic [WIDTH-1:0]   result,
  output logic               overflowTrap
);

  aluCtrl_t ctrl;

  alu_ctrl #(.OP_W(OP_W)) u_ctrl (
    .opCode (opCode),
    .immSel (immSel),
    .ctrl   (ctrl)
  );

  alu_datapath #(
    .WIDTH   (WIDTH),
    .IMM_W   (IMM_W),
    .SHAMT_W (SHAMT_W)
  ) u_dp (
    .opA          (opA),
    .opB          (opB),
    .imm          (imm),
    .shamt        (shamt),
    .ctrl         (ctrl),
    .result       (result),
    .overflowTrap (overflowTrap)
  );

endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker
  import alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int IMM_W   = 16,
  parameter int OP_W    = 5,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [IMM_W-1:0]   imm,
  input logic               immSel,
  input logic [SHAMT_W-1:0] shamt,
  input logic [OP_W-1:0]    opCode,
  input logic [WIDTH-1:0]   result,
  input logic               overflowTrap
);

  localparam int EXT_W = WIDTH - IMM_W;

  logic known;
  logic [WIDTH-1:0] zeroExtB;

  always_comb begin
    known    = !$isunknown({opA, opB, imm, immSel, shamt, opCode});
    zeroExtB = immSel ? {{EXT_W{1'b0}}, imm} : opB;
    if (known) begin
      // R3: only trapping add/subtract may raise the flag
      a_r3_no_overflow: assert (!overflowTrap || opCode == OP_ADD || opCode == OP_SUB)
        else $error("overflow raised by non-trapping code %0d", opCode);
      // R6: compare results are a single bit
      if (opCode == OP_SLT || opCode == OP_SLTU) begin
        a_r6_bool_result: assert (result[WIDTH-1:1] == '0)
          else $error("set-less-than upper bits nonzero");
      end
      // R9: upper-immediate clears low half and carries imm above it
      if (opCode == OP_LUI) begin
        a_r9_upper_imm: assert (result == {imm, {EXT_W{1'b0}}})
          else $error("upper immediate wrong");
      end
      // R5: NOR against zero-extended second operand
      if (opCode == OP_NOR) begin
        a_r5_nor: assert (result == ~(opA | zeroExtB))
          else $error("nor wrong");
      end
      // R10: undefined codes are quiet
      if (opCode > OP_LUI) begin
        a_r10_undef_zero: assert (result == '0 && !overflowTrap)
          else $error("undefined code not zero");
      end
      // R8: variable shift count of zero leaves A unchanged
      if ((opCode == OP_SLLV || opCode == OP_SRLV || opCode == OP_SRAV) &&
          opB[SHAMT_W-1:0] == '0) begin
        a_r8_var_zero: assert (result == opA)
          else $error("variable shift by zero altered A");
      end
    end
  end

endmodule

bind alu_core alu_core_checker #(
  .WIDTH   (WIDTH),
  .IMM_W   (IMM_W),
  .OP_W    (OP_W),
  .SHAMT_W (SHAMT_W)
) u_alu_chk (
  .opA          (opA),
  .opB          (opB),
  .imm          (imm),
  .immSel       (immSel),
  .shamt        (shamt),
  .opCode       (opCode),
  .result       (result),
  .overflowTrap (overflowTrap)
);

// File: tb/test_alu_core.sv
module test_alu_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] imm = '0;
  logic        immSel = 1'b0;
  logic [4:0]  shamt = '0;
  logic [4:0]  opCode = '0;
  logic [31:0] result;
  logic        overflowTrap;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core i_alu_core (
    .opA(opA), .opB(opB), .imm(imm), .immSel(immSel), .shamt(shamt),
    .opCode(opCode), .result(result), .overflowTrap(overflowTrap)
  );

  function automatic string reqTag(input logic [4:0] op, input logic isImm);
    if (op > 5'd16) return "R10";
    if (op == 5'd16) return "R9";
    if (op >= 5'd13) return "R8";
    if (op >= 5'd10) return "R7";
    if (op >= 5'd8) return isImm ? "R4/R6" : "R6";
    if (op >= 5'd4) return "R5";
    return isImm ? "R4/R1/R2/R3" : "R1/R2/R3";
  endfunction

  // behavioural reference model
  task automatic refModel(input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic isImm,
                          input logic [4:0] sh, input logic [4:0] op,
                          output logic [31:0] r, output logic ovf);
    logic [31:0] bs;
    logic [31:0] bz;
    longint sa;
    longint sb;
    longint s;
    bs  = isImm ? {{16{im[15]}}, im} : b;
    bz  = isImm ? {16'h0, im} : b;
    sa  = longint'($signed(a));
    sb  = longint'($signed(bs));
    r   = '0;
    ovf = 1'b0;
    case (op)
      5'd0, 5'd1: begin
        s = sa + sb; r = s[31:0];
        if (op == 5'd0) ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      5'd2, 5'd3: begin
        s = sa - sb; r = s[31:0];
        if (op == 5'd2) ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      5'd4: r = a & bz;
      5'd5: r = a | bz;
      5'd6: r = a ^ bz;
      5'd7: r = ~(a | bz);
      5'd8: r = (sa < sb) ? 32'd1 : 32'd0;
      5'd9: r = (a < bs) ? 32'd1 : 32'd0;
      5'd10: r = a << sh;
      5'd11: r = a >> sh;
      5'd12: r = $signed(a) >>> sh;
      5'd13: r = a << b[4:0];
      5'd14: r = a >> b[4:0];
      5'd15: r = $signed(a) >>> b[4:0];
      5'd16: r = {im, 16'h0};
      default: r = '0;
    endcase
  endtask

  task automatic applyVec(input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic isImm,
                          input logic [4:0] sh, input logic [4:0] op);
    logic [31:0] expR;
    logic        expO;
    @(posedge clk);
    opA = a; opB = b; imm = im; immSel = isImm; shamt = sh; opCode = op;
    refModel(a, b, im, isImm, sh, op, expR, expO);
    @(negedge clk);
    compared++;
    if (result !== expR || overflowTrap !== expO) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sel=%0b sh=%0d: actual %h/%0b expected %h/%0b",
               reqTag(op, isImm), op, a, b, im, isImm, sh, result, overflowTrap, expR, expO);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
        finishRun();
      end
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    // reset state: all-zero inputs give a zero add and no trap (R1, R3)
    applyVec(32'h0, 32'h0, 16'h0, 1'b0, 5'd0, 5'd0);
    rst = 1'b0;
    // R2 overflow edges
    applyVec(32'h7fffffff, 32'h1, 16'h0, 1'b0, 5'd0, 5'd0);
    applyVec(32'h80000000, 32'h1, 16'h0, 1'b0, 5'd0, 5'd2);
    applyVec(32'h80000000, 32'h80000000, 16'h0, 1'b0, 5'd0, 5'd0);
    applyVec(32'h7ffffffe, 32'h1, 16'h0, 1'b0, 5'd0, 5'd0);
    // R3 non-trapping wrap
    applyVec(32'h7fffffff, 32'h1, 16'h0, 1'b0, 5'd0, 5'd1);
    applyVec(32'h80000000, 32'h1, 16'h0, 1'b0, 5'd0, 5'd3);
    // R4 sign-extended immediate, incl. add-immediate overflow
    applyVec(32'h0, 32'h0, 16'hffff, 1'b1, 5'd0, 5'd1);
    applyVec(32'h80000000, 32'h0, 16'hffff, 1'b1, 5'd0, 5'd0);
    applyVec(32'h5, 32'h0, 16'h8000, 1'b1, 5'd0, 5'd9);
    // R5 zero-extended immediate
    applyVec(32'hffffffff, 32'h0, 16'hffff, 1'b1, 5'd0, 5'd4);
    applyVec(32'h12340000, 32'h0, 16'h8001, 1'b1, 5'd0, 5'd7);
    // R6 signed vs unsigned
    applyVec(32'hffffffff, 32'h1, 16'h0, 1'b0, 5'd0, 5'd8);
    applyVec(32'hffffffff, 32'h1, 16'h0, 1'b0, 5'd0, 5'd9);
    applyVec(32'h80000000, 32'h7fffffff, 16'h0, 1'b0, 5'd0, 5'd8);
    // R7 constant shifts
    applyVec(32'h80000000, 32'h0, 16'h0, 1'b0, 5'd31, 5'd12);
    applyVec(32'h80000000, 32'h0, 16'h0, 1'b0, 5'd31, 5'd11);
    applyVec(32'h00000001, 32'h0, 16'h0, 1'b0, 5'd31, 5'd10);
    // R8 variable shifts with upper bits of B set and immSel ignored
    applyVec(32'hf0000000, 32'hffffffe4, 16'h1234, 1'b1, 5'd1, 5'd14);
    applyVec(32'hf0000000, 32'h00000104, 16'h0, 1'b0, 5'd9, 5'd15);
    applyVec(32'h0000000f, 32'h80000020, 16'h0, 1'b0, 5'd3, 5'd13);
    // R9 upper immediate
    applyVec(32'hdeadbeef, 32'h1, 16'habcd, 1'b1, 5'd0, 5'd16);
    // R10 undefined codes
    applyVec(32'h7fffffff, 32'h1, 16'hffff, 1'b1, 5'd7, 5'd17);
    applyVec(32'h7fffffff, 32'h1, 16'hffff, 1'b0, 5'd7, 5'd31);
    // random sweep over all codes
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = $urandom();
      rb = $urandom();
      if ((i % 7) == 0) ra = {ra[31], 31'h7fffffff} ^ {1'b0, ra[30:0] & 31'h3};
      applyVec(ra, rb, 16'($urandom()), 1'($urandom()), 5'($urandom()), 5'($urandom()));
    end
    done = 1'b1;
    finishRun();
  end

endmodule